// File: doc/BRIEF.md
# Two-Wire Bus Eight-Line Port Expander Target

This block is a target on a two-wire serial bus (I2C). It lets a bus controller drive and read eight general-purpose lines. The controller always opens a transfer with a START condition and an address byte. The block answers only when the seven address bits equal a four-bit family prefix followed by the levels on three strap inputs. Two prefixes exist, picked by a parameter, so two families of eight blocks can share one bus.

In a write, each data byte replaces the output latch that drives the lines. In a read, the block sends the levels it samples on the lines. The outputs behave as quasi-bidirectional lines: a latch bit of 1 is a weak high that anything outside may pull low, so that line works as an input. The serial data output is open-drain. It is modelled as an enable that pulls the wire low when set, and the block never drives a high.

Top module: `i2c_port_expander`

## Requirements
- R1: The address byte is received most significant bit first. Its upper seven bits must equal {prefix, strap[2:0]}, where the prefix is 4'b0100 when ALT_FAMILY=0 and 4'b0111 when ALT_FAMILY=1. On a match, the block holds SDA low during the 9th SCL clock as an acknowledge.
- R2: If the address does not match, the block never pulls SDA. It ignores every following clock, and the output latch keeps its value until the next START.
- R3: Bit 0 of the address byte sets the direction: 0 means the controller writes the latch, 1 means the controller reads the lines.
- R4: In a write, every data byte is acknowledged. port_q takes the byte when SCL falls at the end of its acknowledge clock, and each later byte in the same transfer overwrites it.
- R5: In a read, pin_i is captured when SCL falls after the 8th address bit. That byte is then sent most significant bit first, and SDA changes only while SCL is low.
- R6: If the controller pulls SDA low on the 9th clock of a read byte, pin_i is captured again and the next byte follows. If SDA stays high on that clock, the block releases SDA and stays silent until START or STOP.
- R7: A START (SDA falls while SCL is high) aborts any transfer and restarts address reception. A STOP (SDA rises while SCL is high) returns the block to idle. A partly received data byte never reaches port_q.
- R8: After reset, port_q is 8'hFF (every line weak high and usable as an input) and sda_oe is 0.
- R9: sda_oe only ever becomes active while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap | input | 3 | Low three address bits |
| pin_i | input | 8 | Levels observed on the eight lines |
| port_q | output | 8 | Output latch; 1 is a weak high |

## Verification
The bench aims at these corner cases:
- A repeated START after a few data bits. A design that kept its bit count or shift register would then treat the next address as data.
- A STOP in the middle of a byte. A design that committed partial bytes would corrupt the latch.
- A change on the external lines after the address acknowledge. A design that sampled late would send the new levels instead of the captured ones.
- Addresses where only the strap bits differ, or only the prefix differs. A wrong comparison would acknowledge and overwrite the latch.
- A read ended with no acknowledge from the controller. A design that kept shifting would pull SDA against a STOP that follows.

// File: rtl/i2c_port_expander.sv
module i2c_port_expander #(
  parameter bit ALT_FAMILY  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic [7:0] pin_i,
  output logic [7:0] port_q
);
  localparam logic [3:0] PFX = ALT_FAMILY ? 4'b0111 : 4'b0100;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK, S_SKIP
  } st_t;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;
  st_t  st;
  logic [7:0] shreg;
  logic [2:0] cnt;
  logic ack_on, rw, mack;

  wire scl_s  = scl_sh[SYNC_STAGES-1];
  wire sda_s  = sda_sh[SYNC_STAGES-1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire [7:0] shin = {shreg[6:0], sda_s};
  wire hit = (shin[7:1] == {PFX, strap});

  assign sda_oe = ack_on | ((st == S_RDATA) & ~shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      shreg  <= '0;
      cnt    <= '0;
      ack_on <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      port_q <= '1;
    end else if (start_c) begin
      st     <= S_ADDR;
      cnt    <= '0;
      ack_on <= 1'b0;
      mack   <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      ack_on <= 1'b0;
      mack   <= 1'b0;
    end else begin
      unique case (st)
        S_ADDR, S_WDATA: if (scl_rise) begin
          shreg <= shin;
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (st == S_WDATA) st <= S_WACK;
            else if (hit) begin
              st <= S_AACK;
              rw <= sda_s;
            end else st <= S_SKIP;
          end
        end
        S_AACK: if (scl_fall) begin
          if (!ack_on) begin
            ack_on <= 1'b1;
            if (rw) shreg <= pin_i;
          end else begin
            ack_on <= 1'b0;
            cnt    <= '0;
            st     <= rw ? S_RDATA : S_WDATA;
          end
        end
        S_WACK: if (scl_fall) begin
          if (!ack_on) ack_on <= 1'b1;
          else begin
            ack_on <= 1'b0;
            port_q <= shreg;
            cnt    <= '0;
            st     <= S_WDATA;
          end
        end
        S_RDATA: if (scl_fall) begin
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) st <= S_RACK;
          else shreg <= {shreg[6:0], 1'b0};
        end
        S_RACK: begin
          if (scl_rise) begin
            if (sda_s) st <= S_SKIP;
            else mack <= 1'b1;
          end else if (scl_fall && mack) begin
            mack  <= 1'b0;
            shreg <= pin_i;
            cnt   <= '0;
            st    <= S_RDATA;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module i2c_port_expander_chk #(
  parameter bit ALT_FAMILY = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_c,
  input logic       stop_c,
  input logic [2:0] st,
  input logic       ack_on,
  input logic [7:0] shreg,
  input logic [2:0] strap,
  input logic       sda_oe,
  input logic [7:0] port_q
);
  localparam logic [3:0] PFX = ALT_FAMILY ? 4'b0111 : 4'b0100;
  localparam logic [2:0] C_IDLE = 3'd0, C_ADDR = 3'd1, C_AACK = 3'd2,
                         C_WACK = 3'd4, C_SKIP = 3'd7;

  AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_AACK && !ack_on) |-> shreg[7:1] == {PFX, strap}); // R1
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_SKIP) |-> !sda_oe); // R2
  AST_PORT_ONLY_AFTER_WACK: assert property (@(posedge clk) disable iff (!rst_n)
    (port_q != $past(port_q)) |-> ($past(st) == C_WACK)); // R4
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R9
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == C_ADDR && !sda_oe)); // R7
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == C_IDLE)); // R7
endmodule

bind i2c_port_expander i2c_port_expander_chk #(.ALT_FAMILY(ALT_FAMILY)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c), .stop_c(stop_c),
  .st(st), .ack_on(ack_on), .shreg(shreg), .strap(strap), .sda_oe(sda_oe),
  .port_q(port_q)
);

// File: tb/sim_i2c_port_expander.sv
`timescale 1ns/1ps
module sim_i2c_port_expander;
  localparam int H = 16;
  logic clk = 1'b0;
  logic rst_n, scl, m_sda;
  logic [2:0] strap = 3'b101;
  logic [7:0] ext;
  wire  [7:0] pin;
  wire  sda_oe;
  wire  [7:0] port_q;
  wire  bus_sda = m_sda & ~sda_oe;

  assign pin = port_q & ext;

  i2c_port_expander #(.ALT_FAMILY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda), .sda_oe(sda_oe),
    .strap(strap), .pin_i(pin), .port_q(port_q)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, settle = 0;
  bit live = 0, done = 0;
  logic exp_oe = 1'b0;
  logic [7:0] exp_port = 8'hFF, snap = 8'h00;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      if (settle > 0) settle--;
      else begin
        checks++;
        if (sda_oe !== exp_oe || port_q !== exp_port) begin
          fails++;
          $display("FAIL model R4 R5 R9 act=%b/%h exp=%b/%h",
                   sda_oe, port_q, exp_oe, exp_port);
        end
      end
    end
  end

  task automatic hold();
    repeat (H) @(posedge clk);
    #1;
  endtask
  task automatic drv_scl(logic v);
    scl = v; settle = 5; hold();
  endtask
  task automatic drv_sda(logic v);
    m_sda = v; settle = 5; hold();
  endtask

  task automatic do_start();
    if (!scl) begin
      drv_sda(1'b1);
      drv_scl(1'b1);
    end
    exp_oe = 1'b0;
    drv_sda(1'b0);
    drv_scl(1'b0);
  endtask

  task automatic do_stop();
    drv_sda(1'b0);
    drv_scl(1'b1);
    drv_sda(1'b1);
  endtask

  task automatic send(logic [7:0] b, logic want_ack, logic is_addr, string req);
    for (int i = 7; i >= 0; i--) begin
      drv_sda(b[i]);
      drv_scl(1'b1);
      if (i == 0) begin
        if (is_addr && want_ack && b[0]) snap = exp_port & ext;
        exp_oe = want_ack;
      end
      drv_scl(1'b0);
    end
    drv_sda(1'b1);
    drv_scl(1'b1);
    chk({req, " ack"}, {7'd0, ~bus_sda}, {7'd0, want_ack});
    exp_oe = (is_addr && want_ack && b[0]) ? ~snap[7] : 1'b0;
    if (!is_addr && want_ack) exp_port = b;
    drv_scl(1'b0);
  endtask

  task automatic partial(int n);
    for (int i = 0; i < n; i++) begin
      drv_sda(1'b0);
      drv_scl(1'b1);
      drv_scl(1'b0);
    end
  endtask

  task automatic recv(logic mack, string req);
    logic [7:0] got = 8'h00;
    logic [7:0] want = snap;
    for (int i = 7; i >= 0; i--) begin
      drv_scl(1'b1);
      got[i] = bus_sda;
      exp_oe = (i > 0) ? ~snap[i-1] : 1'b0;
      drv_scl(1'b0);
    end
    chk(req, got, want);
    drv_sda(~mack);
    drv_scl(1'b1);
    if (mack) begin
      snap = exp_port & ext;
      exp_oe = ~snap[7];
    end else exp_oe = 1'b0;
    drv_scl(1'b0);
    drv_sda(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R7 act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; ext = 8'hFF;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    hold();
    live = 1;
    chk("R8 reset port", port_q, 8'hFF);
    chk("R8 reset oe", {7'd0, sda_oe}, 8'h00);

    // write two bytes in one transfer
    do_start();
    send(8'h4A, 1'b1, 1'b1, "R1 R3 write addr");
    send(8'h3C, 1'b1, 1'b0, "R4 byte1");
    chk("R4 port after byte1", port_q, 8'h3C);
    send(8'hA5, 1'b1, 1'b0, "R4 byte2");
    chk("R4 port after byte2", port_q, 8'hA5);
    do_stop();

    // read with late pin change, ack then nack
    ext = 8'hF0;
    do_start();
    send(8'h4B, 1'b1, 1'b1, "R1 R3 read addr");
    ext = 8'h0F;
    recv(1'b1, "R5 first read byte");
    recv(1'b0, "R6 second read byte");
    chk("R6 released after nack", {7'd0, sda_oe}, 8'h00);
    do_stop();
    ext = 8'hFF;

    // strap mismatch
    do_start();
    send(8'h48, 1'b0, 1'b1, "R2 strap mismatch");
    send(8'h00, 1'b0, 1'b0, "R2 data ignored");
    chk("R2 port kept", port_q, 8'hA5);
    do_stop();

    // prefix mismatch
    do_start();
    send(8'h7A, 1'b0, 1'b1, "R1 prefix mismatch");
    send(8'h11, 1'b0, 1'b0, "R1 data ignored");
    chk("R1 port kept", port_q, 8'hA5);
    do_stop();

    // repeated start mid byte
    do_start();
    send(8'h4A, 1'b1, 1'b1, "R7 addr");
    partial(4);
    do_start();
    send(8'h4A, 1'b1, 1'b1, "R7 re-addr");
    send(8'h55, 1'b1, 1'b0, "R7 data");
    chk("R7 port after restart", port_q, 8'h55);
    do_stop();

    // stop mid byte
    do_start();
    send(8'h4A, 1'b1, 1'b1, "R7 addr2");
    partial(3);
    do_stop();
    chk("R7 port after stop abort", port_q, 8'h55);

    // back to weak-high inputs and read external levels
    do_start();
    send(8'h4A, 1'b1, 1'b1, "R8 addr");
    send(8'hFF, 1'b1, 1'b0, "R8 all weak high");
    do_stop();
    ext = 8'h96;
    do_start();
    send(8'h4B, 1'b1, 1'b1, "R3 read addr2");
    recv(1'b0, "R5 external levels");
    do_stop();
    chk("R8 port weak high", port_q, 8'hFF);

    hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule